// File: doc/BRIEF.md
# Dual-Clock FIFO with Speculative Early Flags

This block is a first-in first-out buffer between a write clock domain and a read clock domain. Each side publishes its pointer in Gray code, and the other side samples it through a two-flop synchronizer. The usual confirmed flags (`wr_full`, `rd_not_empty`) come from the second flop. Each side also has an early flag: `wr_free` on the write side, `rd_avail` on the read side. The early flag is computed from the first flop, so it rises one local cycle before the confirmed flag would allow the same operation.

An operation taken under the early flag while the confirmed flag still forbids it is speculative. On the next local cycle the second flop holds the value the first flop held at the time of the operation. If that value differs from the one the speculation used, the side raises a one-cycle fail pulse and restores its pointer from a shadow copy. The write data of a failed write is dropped. A failed read consumes nothing. The client then repeats the operation.

A write is accepted on a `wr_clk` edge where `wr_en && wr_free`. A read is accepted on a `rd_clk` edge where `rd_en && rd_avail`. A speculative write is held in a holding register and reaches storage only once it is confirmed. A pointer that includes a speculative operation is published to the other domain only after confirmation. The inputs `wr_upset` and `rd_upset` let a bench force the first-stage sample to disagree with the later second-stage sample, standing in for a wrong early resolution.

Top module: `spec_sync_fifo`

## Requirements
- R1: After reset, `wr_full`=0, `wr_free`=1, `rd_not_empty`=0, `rd_avail`=0, `wr_fail`=0 and `rd_fail`=0 (with both upset inputs low).
- R2: Every write that does not fail is read out exactly once, in write order, with its data unchanged.
- R3: `wr_full` is 1 when DEPTH entries are held and confirmed, and `rd_not_empty` is 0 when no confirmed entry is held.
- R4: The early flags lead the confirmed ones by exactly one local cycle. After a lone write into an empty FIFO, `rd_avail` rises one `rd_clk` cycle before `rd_not_empty`. After a lone read from a full FIFO, `wr_free` rises one `wr_clk` cycle before `wr_full` falls.
- R5: A fail flag is a single-cycle pulse in the local cycle right after a speculative operation whose confirmed sample contradicts the sample it used. With both upset inputs held low, no fail is ever raised.
- R6: After a fail, the operation is undone. A failed write leaves `wr_full` as it was and its data is never read out. A failed read consumes no entry and leaves `rd_not_empty` as it was. Repeating the operation succeeds.
- R7: While a speculative operation awaits its check, that side's early flag is 0, so no further operation is accepted there.
- R8: When an upset input is 1, that cycle's first-stage sample is read as the peer pointer advanced by one entry. Only the early flag sees this. So `wr_free` is 1 even when the FIFO is full, and `rd_avail` is 1 even when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| wr_upset | input | 1 | Force a wrong first-stage sample on the write side |
| wr_full | output | 1 | Confirmed full flag |
| wr_free | output | 1 | Early free-to-write flag; a write is accepted when `wr_en` is also 1 |
| wr_fail | output | 1 | Pulse: previous speculative write undone |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Entry at the head of the FIFO |
| rd_upset | input | 1 | Force a wrong first-stage sample on the read side |
| rd_not_empty | output | 1 | Confirmed not-empty flag |
| rd_avail | output | 1 | Early data-available flag; a read is accepted when `rd_en` is also 1 |
| rd_fail | output | 1 | Pulse: previous speculative read undone |

## Verification
A write becomes visible on the read side in two steps. `rd_avail` rises on the first `rd_clk` edge after the write pointer is published, and `rd_not_empty` rises one `rd_clk` edge later. The write side mirrors this for a read. The bench counts these edges at `rd_clk` and `wr_clk` falling edges and checks that the early and confirmed flags sit exactly one edge apart. A fail belongs to the operation accepted on the edge just before it, so both the write driver and the read monitor look at the fail output at the very next falling edge. A failed write is taken back out of the scoreboard queue, and a failed read is not compared against it.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic {SIDE_WRITE = 1'b0, SIDE_READ = 1'b1} side_e;
endpackage

// File: rtl/lsf_sync2.sv
module lsf_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_first,
  output logic [W-1:0] q_second
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_first  <= '0;
      q_second <= '0;
    end else begin
      q_first  <= d;
      q_second <= q_first;
    end
  end
endmodule

// File: rtl/lsf_port_ctl.sv
module lsf_port_ctl import lsf_pkg::*; #(
  parameter side_e       SIDE = SIDE_WRITE,
  parameter int unsigned AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic          upset,
  input  logic [AW:0]   peer_gray,
  output logic [AW:0]   pub_gray,
  output logic [AW-1:0] op_addr,
  output logic [AW-1:0] shadow_addr,
  output logic          spec_ok,
  output logic          conf_ok,
  output logic          fail,
  output logic          direct_op,
  output logic          spec_op,
  output logic          confirm
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] gray_step(input logic [PW-1:0] g);
    return to_gray(from_gray(g) + PW'(1));
  endfunction

  function automatic logic ring_full(input logic [PW-1:0] own_bin, input logic [PW-1:0] peer_g);
    logic [PW-1:0] pb;
    pb = from_gray(peer_g);
    return (own_bin[AW] != pb[AW]) && (own_bin[AW-1:0] == pb[AW-1:0]);
  endfunction

  logic [PW-1:0] samp_first, samp_second, early_view;
  logic [PW-1:0] ptr_bin, ptr_nxt, shadow_bin, spec_view;
  logic          pending, spec_room, accept, mismatch;

  lsf_sync2 #(.W(PW)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .d        (peer_gray),
    .q_first  (samp_first),
    .q_second (samp_second)
  );

  assign early_view = upset ? gray_step(samp_first) : samp_first;

  generate
    if (SIDE == SIDE_WRITE) begin : g_wr
      always_comb begin
        conf_ok   = !ring_full(ptr_bin, samp_second);
        spec_room = !ring_full(ptr_bin, early_view);
      end
    end else begin : g_rd
      always_comb begin
        conf_ok   = (samp_second != to_gray(ptr_bin));
        spec_room = (early_view != to_gray(ptr_bin));
      end
    end
  endgenerate

  assign spec_ok     = !pending && spec_room;
  assign accept      = op_en && spec_ok;
  assign spec_op     = accept && !conf_ok;
  assign direct_op   = accept && conf_ok;
  assign mismatch    = (samp_second != spec_view);
  assign fail        = pending && mismatch;
  assign confirm     = pending && !mismatch;
  assign op_addr     = ptr_bin[AW-1:0];
  assign shadow_addr = shadow_bin[AW-1:0];

  always_comb begin
    if (fail)        ptr_nxt = shadow_bin;
    else if (accept) ptr_nxt = ptr_bin + PW'(1);
    else             ptr_nxt = ptr_bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_bin    <= '0;
      shadow_bin <= '0;
      spec_view  <= '0;
      pending    <= 1'b0;
      pub_gray   <= '0;
    end else begin
      ptr_bin <= ptr_nxt;
      pending <= spec_op;
      if (spec_op) begin
        shadow_bin <= ptr_bin;
        spec_view  <= early_view;
      end else begin
        pub_gray <= to_gray(ptr_nxt);
      end
    end
  end

  assert_fail_needs_spec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(spec_op));
  assert_fail_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  assert_rollback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (op_addr == $past(shadow_addr)) && (pub_gray == $past(pub_gray)));
  assert_pending_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spec_op) |-> !spec_ok);
  assert_confirmed_implies_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_ok && !pending) |-> spec_ok);
endmodule

// File: rtl/lsf_store.sv
module lsf_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          direct_wr,
  input  logic          spec_wr,
  input  logic          confirm_wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] held_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] held_data;

  always_ff @(posedge wr_clk) begin
    if (direct_wr)  cells[wr_addr]   <= wr_data;
    if (confirm_wr) cells[held_addr] <= held_data;
    if (spec_wr)    held_data        <= wr_data;
  end

  assign rd_data = cells[rd_addr];

  assert_one_store_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !(direct_wr && confirm_wr) && !(spec_wr && confirm_wr));
endmodule

// File: rtl/spec_sync_fifo.sv
module spec_sync_fifo import lsf_pkg::*; #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_upset,
  output logic          wr_full,
  output logic          wr_free,
  output logic          wr_fail,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rd_upset,
  output logic          rd_not_empty,
  output logic          rd_avail,
  output logic          rd_fail
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW:0]   wr_pub, rd_pub;
  logic [AW-1:0] wr_addr, wr_held_addr, rd_addr, unused_rd_shadow;
  logic          wr_conf, wr_direct, wr_spec, wr_confirm;
  logic          unused_rd_direct, unused_rd_spec, unused_rd_confirm;

  lsf_port_ctl #(.SIDE(SIDE_WRITE), .AW(AW)) wr_ctl_i (
    .clk         (wr_clk),
    .rst_n       (wr_rst_n),
    .op_en       (wr_en),
    .upset       (wr_upset),
    .peer_gray   (rd_pub),
    .pub_gray    (wr_pub),
    .op_addr     (wr_addr),
    .shadow_addr (wr_held_addr),
    .spec_ok     (wr_free),
    .conf_ok     (wr_conf),
    .fail        (wr_fail),
    .direct_op   (wr_direct),
    .spec_op     (wr_spec),
    .confirm     (wr_confirm)
  );

  lsf_port_ctl #(.SIDE(SIDE_READ), .AW(AW)) rd_ctl_i (
    .clk         (rd_clk),
    .rst_n       (rd_rst_n),
    .op_en       (rd_en),
    .upset       (rd_upset),
    .peer_gray   (wr_pub),
    .pub_gray    (rd_pub),
    .op_addr     (rd_addr),
    .shadow_addr (unused_rd_shadow),
    .spec_ok     (rd_avail),
    .conf_ok     (rd_not_empty),
    .fail        (rd_fail),
    .direct_op   (unused_rd_direct),
    .spec_op     (unused_rd_spec),
    .confirm     (unused_rd_confirm)
  );

  assign wr_full = !wr_conf;

  lsf_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .direct_wr  (wr_direct),
    .spec_wr    (wr_spec),
    .confirm_wr (wr_confirm),
    .wr_addr    (wr_addr),
    .held_addr  (wr_held_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/spec_sync_fifo_tb_top.sv
module spec_sync_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DEPTH      = 8;
  localparam int DW         = 8;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, wr_upset = 0, rd_en = 0, rd_upset = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, wr_free, wr_fail, rd_not_empty, rd_avail, rd_fail;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  spec_sync_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_upset(wr_upset), .wr_full(wr_full), .wr_free(wr_free), .wr_fail(wr_fail),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_upset(rd_upset), .rd_not_empty(rd_not_empty), .rd_avail(rd_avail), .rd_fail(rd_fail)
  );

  int n_checks = 0, n_fail = 0;
  int wr_fail_seen = 0, rd_fail_seen = 0, rd_budget = 0;
  bit rd_up_req = 0, finished = 0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard driver: pushes on acceptance, withdraws on a fail pulse.
  task automatic write_item(input logic [DW-1:0] d, input bit up);
    bit done = 0, first = 1, acc;
    while (!done) begin
      @(negedge wr_clk);
      wr_en = 1; wr_data = d; wr_upset = up && first;
      #1 acc = wr_free;
      if (acc) exp_q.push_back(d);
      @(posedge wr_clk); #1 wr_en = 0; wr_upset = 0;
      if (acc) begin
        first = 0;
        @(negedge wr_clk);
        if (wr_fail) begin
          void'(exp_q.pop_back());
          wr_fail_seen++;
        end else done = 1;
      end
    end
  endtask

  // Monitor: checks each accepted read one cycle later, after its fail window.
  initial begin
    bit pend = 0;
    logic [DW-1:0] got;
    forever begin
      @(negedge rd_clk);
      if (pend) begin
        pend = 0;
        if (rd_fail) begin
          rd_fail_seen++;
          rd_up_req = 0;
        end else begin
          rd_budget--;
          if (exp_q.size() == 0) chk(0, "R2 unexpected read", int'(got), -1);
          else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R2 read data order", int'(got), int'(e));
          end
        end
      end
      rd_en = (rd_budget > 0); rd_upset = rd_up_req;
      #1;
      pend = rd_en && rd_avail;
      got = rd_data;
      @(posedge rd_clk); #1 rd_en = 0; rd_upset = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge rd_clk);
    #1 wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge wr_clk);
    // R1 reset state
    chk(wr_full == 0, "R1 wr_full", wr_full, 0);
    chk(wr_free == 1, "R1 wr_free", wr_free, 1);
    chk(rd_not_empty == 0, "R1 rd_not_empty", rd_not_empty, 0);
    chk(rd_avail == 0, "R1 rd_avail", rd_avail, 0);
    chk(wr_fail == 0 && rd_fail == 0, "R1 fail flags", wr_fail | rd_fail, 0);

    // R4 read side: early flag one rd cycle ahead of confirmed
    write_item(8'h11, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge rd_clk);
      if (rd_avail) break;
    end
    chk(rd_avail == 1, "R4 rd_avail rose", rd_avail, 1);
    chk(rd_not_empty == 0, "R4 rd_not_empty lags", rd_not_empty, 0);
    @(negedge rd_clk);
    chk(rd_not_empty == 1, "R4 rd_not_empty one cycle later", rd_not_empty, 1);

    // R2 and R5: streamed traffic, no upsets, no fails
    rd_budget = 1000;
    for (int i = 0; i < 24; i++) write_item(DW'(8'h20 + i), 0);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R2 stream drained", exp_q.size(), 0);
    chk(wr_fail_seen == 0 && rd_fail_seen == 0, "R5 no fail without upset",
        wr_fail_seen + rd_fail_seen, 0);
    rd_budget = 0;
    repeat (4) @(negedge rd_clk);

    // R3 fill to full
    for (int i = 0; i < DEPTH; i++) write_item(DW'(8'h40 + i), 0);
    repeat (6) @(negedge wr_clk);
    chk(wr_full == 1, "R3 wr_full at depth", wr_full, 1);
    chk(wr_free == 0, "R3 wr_free low at depth", wr_free, 0);

    // R8, R5, R6: upset write while full
    @(negedge wr_clk);
    wr_en = 1; wr_data = 8'hEE; wr_upset = 1;
    #1 chk(wr_free == 1, "R8 upset raises wr_free", wr_free, 1);
    @(posedge wr_clk); #1 wr_en = 0; wr_upset = 0;
    @(negedge wr_clk);
    chk(wr_fail == 1, "R5 wr_fail pulse", wr_fail, 1);
    chk(wr_free == 0, "R7 wr_free low while checking", wr_free, 0);
    @(negedge wr_clk);
    chk(wr_fail == 0, "R5 wr_fail single cycle", wr_fail, 0);
    chk(wr_full == 1, "R6 wr_full kept after rollback", wr_full, 1);

    // R4 write side
    rd_budget = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge wr_clk);
      if (wr_free) break;
    end
    chk(wr_free == 1, "R4 wr_free rose", wr_free, 1);
    chk(wr_full == 1, "R4 wr_full lags", wr_full, 1);
    @(negedge wr_clk);
    chk(wr_full == 0, "R4 wr_full falls one cycle later", wr_full, 0);

    // R6 and R3: remaining entries drain in order, dropped write never appears
    rd_budget = 1000;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge rd_clk);
    repeat (6) @(negedge rd_clk);
    chk(exp_q.size() == 0, "R6 no extra entry after failed write", exp_q.size(), 0);
    chk(rd_not_empty == 0, "R3 rd_not_empty low when empty", rd_not_empty, 0);
    rd_budget = 0;
    repeat (2) @(negedge rd_clk);

    // R8, R5, R6: upset read while empty
    rd_budget = 1; rd_up_req = 1;
    for (int i = 0; i < 30 && rd_fail_seen == 0; i++) @(negedge rd_clk);
    chk(rd_fail_seen == 1, "R5 rd_fail pulse", rd_fail_seen, 1);
    @(negedge rd_clk);
    chk(rd_fail == 0, "R5 rd_fail single cycle", rd_fail, 0);
    chk(rd_not_empty == 0, "R6 rd_not_empty kept after rollback", rd_not_empty, 0);
    chk(rd_budget == 1, "R6 failed read consumed nothing", rd_budget, 1);
    write_item(8'h5A, 0);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge rd_clk);
    repeat (3) @(negedge rd_clk);
    chk(exp_q.size() == 0 && rd_budget == 0, "R6 repeated read succeeds",
        exp_q.size() + rd_budget, 0);
    chk(rd_fail_seen == 1, "R5 only one read fail", rd_fail_seen, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule